// File: doc/BRIEF.md
# Serial Transmit Unit with Queue Status

This block is the transmit half of a serial port. Software reaches it through a small register port: a write to the data slot queues a byte, the line control slot picks the character length and whether the queue is used, and the control slot holds the enables. A shift stage turns each queued byte into a frame on the `txd` line. Each frame has one low start bit, 5 to 8 data bits sent least significant bit first, and one high stop bit. There is no parity. Each bit lasts 16 pulses of an externally supplied `baud_tick`. The line rests high.

Software reads a status word to learn whether it may write. The "full" bit is the only back-pressure the block offers. A data write made while the buffer is full is dropped without any indication, so the writer must poll "full" before each write. When the queue is switched off, the buffer shrinks to a single holding slot, and the empty and full bits then describe that slot. The busy bit rises as soon as any byte is waiting, even while the port is disabled. It stays high until the stop bit of the last character has left the shift stage. Clearing an enable never cuts a character short.

The interrupt clear slot takes writes and has no effect. The receive empty status bit always reads as set, because this block contains no receiver.

Top module: `serial_tx_unit`

## Requirements
- R1: After reset, the status word at offset 0x18 reads 0x90 (bit 7 transmit empty = 1, bit 5 full = 0, bit 4 receive empty = 1, bit 3 busy = 0), the control word at 0x30 reads 0, and `txd` is high.
- R2: A frame is one low start bit, then the data bits least significant bit first, then one high stop bit, each bit held for 16 `baud_tick` pulses; `txd` changes only on a cycle with `baud_tick` high while a frame is in progress.
- R3: Bits 6:5 of the line control word at 0x2C select the data length: 00 = 5, 01 = 6, 10 = 7, 11 = 8 bits, taken from the low bits of the written byte.
- R4: With bit 4 of the line control word set, the buffer holds 16 bytes sent in write order; status bit 5 is set when it holds 16, and a write to offset 0x00 while full is dropped.
- R5: With bit 4 of the line control word clear, the buffer holds one byte; status bit 5 is set and bit 7 clear while it is occupied, and a further write is dropped.
- R6: Status bit 7 reflects only the buffer: it is set once the last byte has moved into the shift stage, even though that character is still on the line.
- R7: Status bit 3 is set whenever the buffer holds a byte, even with the port disabled, and clears only after the stop bit of the last character ends.
- R8: A character starts only when both bit 0 (port enable) and bit 8 (transmit enable) of the control word at 0x30 are set; bit 9 is stored and read back but has no effect.
- R9: Clearing an enable during a character lets that character finish, and no further character starts; queued bytes stay queued.
- R10: A write to the interrupt clear slot at 0x44 changes no state, and the receive empty bit 4 always reads 1.
- R11: Whenever status bit 3 is clear, `txd` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| baud_tick | input | 1 | One-cycle pulse at 16 times the bit rate |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Byte offset of the register being written or read |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| txd | output | 1 | Serial output line |

## Verification
The assertions assume that `baud_tick` is a single-cycle pulse and that the register port is used one access per cycle. They also assume reset is held for at least one edge before any write. The stimulus generates the tick every second cycle and drives every access from one sequential process. Whenever the bench relies on the port's reaction to a write, it polls the status word and does not assume a fixed cycle count. Dropped writes are checked through the serial line: the bench confirms that only the accepted bytes appear there, in order.

// File: rtl/serial_tx_pkg.sv
package serial_tx_pkg;
  localparam logic [7:0] OFS_DATA  = 8'h00;
  localparam logic [7:0] OFS_FLAGS = 8'h18;
  localparam logic [7:0] OFS_LINE  = 8'h2C;
  localparam logic [7:0] OFS_CTRL  = 8'h30;
  localparam logic [7:0] OFS_ICLR  = 8'h44;

  typedef enum logic [1:0] {
    SH_IDLE  = 2'd0,
    SH_START = 2'd1,
    SH_DATA  = 2'd2,
    SH_STOP  = 2'd3
  } sh_state_t;
endpackage

// File: rtl/serial_tx_queue.sv
module serial_tx_queue #(
  parameter int W     = 8,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          single_slot,
  input  logic          push,
  input  logic [W-1:0]  push_data,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic          empty,
  output logic          full,
  output logic [AW:0]   count
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          do_push, do_pop;

  assign empty   = (count == '0);
  assign full    = single_slot ? !empty : (count == (AW+1)'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (do_push) wp <= (wp == AW'(DEPTH-1)) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == AW'(DEPTH-1)) ? '0 : rp + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/serial_tx_shifter.sv
module serial_tx_shifter
  import serial_tx_pkg::*;
#(
  parameter int W     = 8,
  parameter int TICKS = 16,
  localparam int TCW  = $clog2(TICKS)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         load,
  input  logic [W-1:0] din,
  input  logic [1:0]   len_code,
  output logic         active,
  output logic         txd
);
  sh_state_t      state;
  logic [TCW-1:0] tcnt;
  logic [2:0]     bidx, last;
  logic [W-1:0]   sh;
  logic           bit_end;

  assign bit_end = tick && (tcnt == TCW'(TICKS-1));
  assign active  = (state != SH_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= SH_IDLE;
      tcnt  <= '0;
      bidx  <= '0;
      last  <= '0;
      sh    <= '0;
    end else if (state == SH_IDLE) begin
      if (load) begin
        state <= SH_START;
        tcnt  <= '0;
        sh    <= din;
        last  <= 3'd4 + {1'b0, len_code};
      end
    end else if (tick) begin
      tcnt <= bit_end ? '0 : tcnt + 1'b1;
      if (bit_end) begin
        case (state)
          SH_START: begin
            state <= SH_DATA;
            bidx  <= '0;
          end
          SH_DATA: begin
            sh <= sh >> 1;
            if (bidx == last) state <= SH_STOP;
            else              bidx  <= bidx + 1'b1;
          end
          default: state <= SH_IDLE;
        endcase
      end
    end
  end

  always_comb begin
    case (state)
      SH_START: txd = 1'b0;
      SH_DATA:  txd = sh[0];
      default:  txd = 1'b1;
    endcase
  end
endmodule

// File: rtl/serial_tx_unit.sv
module serial_tx_unit
  import serial_tx_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int TICKS  = 16,
  parameter int DATA_W = 32,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              reg_wr,
  input  logic [7:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              txd
);
  logic [1:0] len_code;
  logic       queue_on;
  logic       port_en, tx_en, rx_en;
  logic       q_empty, q_full, q_pop, sh_active, busy, start_ok;
  logic [7:0] q_head;
  logic [AW:0] q_count;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      len_code <= '0;
      queue_on <= 1'b0;
      port_en  <= 1'b0;
      tx_en    <= 1'b0;
      rx_en    <= 1'b0;
    end else if (reg_wr) begin
      if (reg_addr == OFS_LINE) begin
        len_code <= reg_wdata[6:5];
        queue_on <= reg_wdata[4];
      end
      if (reg_addr == OFS_CTRL) begin
        port_en <= reg_wdata[0];
        tx_en   <= reg_wdata[8];
        rx_en   <= reg_wdata[9];
      end
    end
  end

  assign start_ok = port_en && tx_en && !sh_active && !q_empty;
  assign q_pop    = start_ok;
  assign busy     = !q_empty || sh_active;

  serial_tx_queue #(.W(8), .DEPTH(DEPTH)) queue_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .single_slot (!queue_on),
    .push        (reg_wr && (reg_addr == OFS_DATA)),
    .push_data   (reg_wdata[7:0]),
    .pop         (q_pop),
    .head        (q_head),
    .empty       (q_empty),
    .full        (q_full),
    .count       (q_count)
  );

  serial_tx_shifter #(.W(8), .TICKS(TICKS)) shift_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (baud_tick),
    .load     (start_ok),
    .din      (q_head),
    .len_code (len_code),
    .active   (sh_active),
    .txd      (txd)
  );

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      OFS_FLAGS: begin
        reg_rdata[7] = q_empty;
        reg_rdata[5] = q_full;
        reg_rdata[4] = 1'b1;
        reg_rdata[3] = busy;
      end
      OFS_LINE: begin
        reg_rdata[6:5] = len_code;
        reg_rdata[4]   = queue_on;
      end
      OFS_CTRL: begin
        reg_rdata[0] = port_en;
        reg_rdata[8] = tx_en;
        reg_rdata[9] = rx_en;
      end
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/serial_tx_chk.sv
module serial_tx_chk #(
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input logic        clk,
  input logic        rst_n,
  input logic        baud_tick,
  input logic        txd,
  input logic        busy,
  input logic        q_empty,
  input logic        q_full,
  input logic [AW:0] q_count,
  input logic        sh_active,
  input logic        port_en,
  input logic        tx_en
);
  assert_idle_high_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> txd);

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    q_count <= (AW+1)'(DEPTH));

  assert_flags_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(q_empty && q_full));

  assert_gate_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!(port_en && tx_en) && !sh_active) |=> !sh_active);

  assert_line_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_active && !baud_tick) |=> $stable(txd));
endmodule

bind serial_tx_unit serial_tx_chk #(.DEPTH(DEPTH)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .baud_tick (baud_tick),
  .txd       (txd),
  .busy      (busy),
  .q_empty   (q_empty),
  .q_full    (q_full),
  .q_count   (q_count),
  .sh_active (sh_active),
  .port_en   (port_en),
  .tx_en     (tx_en)
);

// File: tb/serial_tx_unit_tb_top.sv
`timescale 1ns/1ps
module serial_tx_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        baud_tick = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = 8'h00;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        txd;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  serial_tx_unit dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .baud_tick (baud_tick),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .txd       (txd)
  );

  // Line decoder plus tick generator (one tick every second cycle).
  int  exp_len = 8;
  int  rx_log [0:255];
  int  rx_cnt = 0;
  int  frame_err = 0;
  bit  dec_on = 1'b0;
  int  dec_ticks = 0;
  int  dec_val = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (!dec_on) begin
        if (txd == 1'b0) begin
          dec_on = 1'b1; dec_ticks = 0; dec_val = 0;
        end
      end else if (baud_tick) begin
        dec_ticks++;
        if (dec_ticks % 16 == 8) begin
          int i;
          i = dec_ticks / 16;
          if (i == 0) begin
            if (txd != 1'b0) frame_err++;
          end else if (i <= exp_len) begin
            dec_val = dec_val | (int'(txd) << (i - 1));
          end else begin
            if (txd != 1'b1) frame_err++;
            rx_log[rx_cnt % 256] = dec_val;
            rx_cnt++;
            dec_on = 1'b0;
          end
        end
      end
    end
    baud_tick = ~baud_tick;
  end

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] f;
    for (int k = 0; k < 20000; k++) begin
      rd(8'h18, f);
      if (!f[3]) break;
    end
    repeat (4) @(negedge clk);
  endtask

  localparam int NV = 6;
  // {length code, byte}
  localparam logic [9:0] VEC [NV] = '{
    {2'b11, 8'hA5}, {2'b00, 8'h1F}, {2'b01, 8'h2C},
    {2'b10, 8'h55}, {2'b11, 8'h00}, {2'b11, 8'hFF}
  };

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] f;
    int base;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state, R11 idle line
    rd(8'h18, f); check("R1 flags", int'(f), 32'h90);
    rd(8'h30, f); check("R1 ctrl", int'(f), 0);
    check("R11 idle txd", int'(txd), 1);

    // R2 / R3 vector walk
    wr(8'h30, 32'h301);
    foreach (VEC[v]) begin
      base = rx_cnt;
      exp_len = 5 + int'(VEC[v][9:8]);
      wr(8'h2C, 32'h10 | (32'(VEC[v][9:8]) << 5));
      wr(8'h00, 32'(VEC[v][7:0]));
      wait_idle();
      check("R3 count", rx_cnt - base, 1);
      check("R2 R3 byte", rx_log[base % 256], int'(VEC[v][7:0]) & ((1 << exp_len) - 1));
    end
    check("R2 framing", frame_err, 0);

    // R5 single slot, R7 busy while disabled, R8 gating
    exp_len = 8;
    wr(8'h30, 32'h0);
    wr(8'h2C, 32'h60);
    base = rx_cnt;
    wr(8'h00, 32'h3C);
    rd(8'h18, f); check("R5 R7 flags occupied", int'(f), 32'h38);
    wr(8'h00, 32'h99);
    wr(8'h30, 32'h001);
    repeat (100) @(negedge clk);
    rd(8'h18, f); check("R8 port only", int'(f), 32'h38);
    wr(8'h30, 32'h100);
    repeat (100) @(negedge clk);
    check("R8 no line activity", rx_cnt - base, 0);
    wr(8'h30, 32'h101);
    repeat (6) @(negedge clk);
    rd(8'h18, f); check("R6 empty while shifting", int'(f), 32'h98);
    wait_idle();
    repeat (400) @(negedge clk);
    check("R5 dropped write", rx_cnt - base, 1);
    check("R5 byte", rx_log[base % 256], 32'h3C);
    rd(8'h18, f); check("R7 busy cleared", int'(f), 32'h90);

    // R4 queue depth and overflow drop
    wr(8'h30, 32'h0);
    wr(8'h2C, 32'h70);
    base = rx_cnt;
    for (int i = 0; i < 15; i++) wr(8'h00, 32'(i * 3 + 1));
    rd(8'h18, f); check("R4 not full at 15", int'(f), 32'h18);
    wr(8'h00, 32'd46);
    rd(8'h18, f); check("R4 full at 16", int'(f), 32'h38);
    wr(8'h00, 32'hEE);
    wr(8'h30, 32'h101);
    wait_idle();
    repeat (400) @(negedge clk);
    check("R4 count", rx_cnt - base, 16);
    for (int i = 0; i < 16; i++)
      check("R4 order", rx_log[(base + i) % 256], i * 3 + 1);

    // R9 disable during a character
    base = rx_cnt;
    wr(8'h00, 32'h81);
    wr(8'h00, 32'h42);
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      if (txd == 1'b0) break;
    end
    repeat (40) @(negedge clk);
    wr(8'h30, 32'h0);
    repeat (1000) @(negedge clk);
    check("R9 one finished", rx_cnt - base, 1);
    check("R9 byte", rx_log[base % 256], 32'h81);
    rd(8'h18, f); check("R9 held in queue", int'(f), 32'h18);
    check("R9 line idle", int'(txd), 1);
    wr(8'h30, 32'h101);
    wait_idle();
    check("R9 resume", rx_log[(base + 1) % 256], 32'h42);

    // R10 interrupt clear ignored
    wr(8'h44, 32'h7FF);
    rd(8'h30, f); check("R10 ctrl kept", int'(f), 32'h101);
    rd(8'h2C, f); check("R10 line kept", int'(f), 32'h70);
    rd(8'h18, f); check("R10 flags", int'(f), 32'h90);
    check("R2 framing end", frame_err, 0);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule